// File: doc/BRIEF.md
# PCI Target Termination Controller

This block sits in a 32-bit PCI target between the local-side logic and the bus control pins DEVSEL#, TRDY# and STOP#. Once address decode has claimed a transaction, the block drives the target's control pins through every data phase. It also decides how the transaction ends. The local side may raise a graceful stop request or an abort request. The block turns a graceful stop into a retry when no data phase has yet been offered in the current transaction, and into a disconnect otherwise.

An abort request becomes a target abort. It always wins over a stop request raised in the same clock. During a configuration transaction, both kinds of request are ignored. After the block asserts STOP#, it holds it until the master deasserts FRAME#. It then releases all three pins together, one clock after the final phase in which IRDY# is asserted.

The outcome of each transaction is reported on a 2-bit status output. A sticky flag records that a target abort was signalled.

Top module: `pci_tgt_term_ctl`

## Requirements
- R1: During and directly after reset, devsel_n, trdy_n and stop_n are 1, term_code is 00 and abort_flag is 0.
- R2: When sel_hit is 1 and frame_n is 0 while the block is idle, devsel_n is 0 from the next clock, with trdy_n and stop_n at 1 and term_code cleared to 00.
- R3: During data phases with no termination pending, trdy_n on the next clock is the inverse of loc_rdy.
- R4: A stop request is a retry when loc_rdy has not been 1 during any data-phase clock of the transaction, including the current one. On the next clock it gives devsel_n 0, stop_n 0, trdy_n 1 and term_code 01.
- R5: Any other stop request is a disconnect, with term_code 10 and stop_n 0 on the next clock. trdy_n is 0 on that clock if loc_rdy is 1 in the request clock (disconnect with data), and 1 otherwise.
- R6: An abort request in a data-phase clock, after DEVSEL# has been driven for at least one clock, gives devsel_n 1, stop_n 0, trdy_n 1 and term_code 11 on the next clock. A request in the claim clock itself is not acted on.
- R7: When abort and stop requests arrive in the same clock, the abort wins.
- R8: In a transaction claimed with sel_cfg set to 1, stop and abort requests have no effect on any output.
- R9: Once stop_n is 0, it stays 0 while frame_n is 0. In that stop state, trdy_n returns to 1 after a phase with irdy_n at 0. After a clock with frame_n 1 and irdy_n 0, all three pins are 1 together.
- R10: abort_flag is set by each target abort and cleared by abort_clr. Set wins when both fall in the same clock.
- R11: A clock with frame_n 1, irdy_n 0 and trdy_n 0 during data phases completes the transaction. All three pins return to 1 on the next clock, and term_code stays 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_n | input | 1 | FRAME# from the bus |
| irdy_n | input | 1 | IRDY# from the bus |
| sel_hit | input | 1 | Address decode claims the current address phase |
| sel_cfg | input | 1 | The claimed transaction is a configuration access |
| loc_rdy | input | 1 | Local side supplies or accepts data this clock |
| loc_stop_req | input | 1 | Local graceful stop request |
| loc_abort_req | input | 1 | Local abort request |
| abort_clr | input | 1 | Write-one-to-clear strobe for abort_flag |
| devsel_n | output | 1 | DEVSEL# drive |
| trdy_n | output | 1 | TRDY# drive |
| stop_n | output | 1 | STOP# drive |
| term_code | output | 2 | 00 normal, 01 retry, 10 disconnect, 11 target abort |
| abort_flag | output | 1 | Sticky: a target abort was signalled |

## Verification
Three pairs of events can fall in the same clock.

The first pair is a stop request and an abort request. The bench raises both together and expects the target-abort pattern, not a retry or a disconnect.

The second pair is a stop request and the local side's first ready. The bench raises them together with no earlier data, and a correct block must report a disconnect with data rather than a retry.

The third pair is an abort and the sticky-flag clear strobe, where the flag must stay set.

A behavioural model in the bench predicts every pin on every clock, and the bench compares the design against it throughout.

// File: rtl/pci_tgt_term_pkg.sv
package pci_tgt_term_pkg;
  localparam int CODE_W = 2;

  typedef enum logic [CODE_W-1:0] {
    TC_NONE  = 2'b00,
    TC_RETRY = 2'b01,
    TC_DISC  = 2'b10,
    TC_ABORT = 2'b11
  } term_code_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_DATA = 2'b01,
    ST_STOP = 2'b10
  } seq_st_e;

  // Ending selection: abort first, then stop split by data history.
  function automatic term_code_e pick_term(input logic live, input logic cfg,
                                           input logic abort_rq, input logic stop_rq,
                                           input logic seen, input logic rdy);
    if (!live || cfg)       return TC_NONE;
    if (abort_rq)           return TC_ABORT;
    if (!stop_rq)           return TC_NONE;
    if (!seen && !rdy)      return TC_RETRY;
    return TC_DISC;
  endfunction
endpackage

// File: rtl/pci_tgt_phase_track.sv
module pci_tgt_phase_track (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic in_data,
  input  logic loc_rdy,
  output logic seen
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  seen <= 1'b0;
    else if (start)              seen <= 1'b0;
    else if (in_data && loc_rdy) seen <= 1'b1;
  end
endmodule

// File: rtl/pci_tgt_term_arb.sv
module pci_tgt_term_arb
  import pci_tgt_term_pkg::*;
(
  input  logic       live,
  input  logic       cfg,
  input  logic       abort_rq,
  input  logic       stop_rq,
  input  logic       seen,
  input  logic       rdy,
  output term_code_e choice
);
  always_comb choice = pick_term(live, cfg, abort_rq, stop_rq, seen, rdy);
endmodule

// File: rtl/pci_tgt_abort_sticky.sv
module pci_tgt_abort_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr_ev,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag <= 1'b0;
    else if (set_ev) flag <= 1'b1;
    else if (clr_ev) flag <= 1'b0;
  end
endmodule

// File: rtl/pci_tgt_term_ctl.sv
module pci_tgt_term_ctl
  import pci_tgt_term_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic              sel_hit,
  input  logic              sel_cfg,
  input  logic              loc_rdy,
  input  logic              loc_stop_req,
  input  logic              loc_abort_req,
  input  logic              abort_clr,
  output logic              devsel_n,
  output logic              trdy_n,
  output logic              stop_n,
  output logic [CODE_W-1:0] term_code,
  output logic              abort_flag
);
  seq_st_e    st_q, st_d;
  logic       dev_q, dev_d, trdy_q, trdy_d, stop_q, stop_d;
  logic       cfg_q, cfg_d;
  term_code_e code_q, code_d;

  // Named events for the checker.
  logic       start_ev, in_data, release_ev, abort_fire, cfg_txn, seen_q;
  term_code_e choice;

  assign in_data = (st_q == ST_DATA);
  assign cfg_txn = cfg_q;

  pci_tgt_phase_track u_track (
    .clk(clk), .rst_n(rst_n), .start(start_ev), .in_data(in_data),
    .loc_rdy(loc_rdy), .seen(seen_q)
  );

  pci_tgt_term_arb u_arb (
    .live(in_data), .cfg(cfg_q), .abort_rq(loc_abort_req), .stop_rq(loc_stop_req),
    .seen(seen_q), .rdy(loc_rdy), .choice(choice)
  );

  always_comb begin
    st_d = st_q; dev_d = dev_q; trdy_d = trdy_q; stop_d = stop_q;
    cfg_d = cfg_q; code_d = code_q;
    start_ev = 1'b0; release_ev = 1'b0; abort_fire = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (!frame_n && sel_hit) begin
          st_d = ST_DATA; dev_d = 1'b0; trdy_d = 1'b1; stop_d = 1'b1;
          cfg_d = sel_cfg; code_d = TC_NONE; start_ev = 1'b1;
        end
      end
      ST_DATA: begin
        if (frame_n && (irdy_n || !trdy_q)) begin
          release_ev = 1'b1;
        end else begin
          unique case (choice)
            TC_ABORT: begin
              st_d = ST_STOP; dev_d = 1'b1; stop_d = 1'b0; trdy_d = 1'b1;
              abort_fire = 1'b1;
            end
            TC_RETRY: begin
              st_d = ST_STOP; stop_d = 1'b0; trdy_d = 1'b1;
            end
            TC_DISC: begin
              st_d = ST_STOP; stop_d = 1'b0; trdy_d = ~loc_rdy;
            end
            default: trdy_d = ~loc_rdy;
          endcase
          if (choice != TC_NONE) code_d = choice;
        end
      end
      ST_STOP: begin
        if (frame_n && !irdy_n) release_ev = 1'b1;
        else                    trdy_d = trdy_q | ~irdy_n;
      end
      default: st_d = ST_IDLE;
    endcase
    if (release_ev) begin
      st_d = ST_IDLE; dev_d = 1'b1; trdy_d = 1'b1; stop_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; dev_q <= 1'b1; trdy_q <= 1'b1; stop_q <= 1'b1;
      cfg_q <= 1'b0; code_q <= TC_NONE;
    end else begin
      st_q <= st_d; dev_q <= dev_d; trdy_q <= trdy_d; stop_q <= stop_d;
      cfg_q <= cfg_d; code_q <= code_d;
    end
  end

  pci_tgt_abort_sticky u_sticky (
    .clk(clk), .rst_n(rst_n), .set_ev(abort_fire), .clr_ev(abort_clr), .flag(abort_flag)
  );

  assign devsel_n  = dev_q;
  assign trdy_n    = trdy_q;
  assign stop_n    = stop_q;
  assign term_code = code_q;
endmodule

// File: rtl/pci_tgt_term_chk.sv
module pci_tgt_term_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_n,
  input logic       devsel_n,
  input logic       trdy_n,
  input logic       stop_n,
  input logic [1:0] term_code,
  input logic       abort_flag,
  input logic       abort_fire,
  input logic       cfg_txn,
  input logic       in_data
);
  assert_cfg_nostop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_txn |-> stop_n);
  assert_retry_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (term_code == 2'b01 && !stop_n) |-> (!devsel_n && trdy_n));
  assert_abort_after_devsel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    abort_fire |-> (!devsel_n && in_data));
  assert_abort_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
    abort_fire |=> (devsel_n && !stop_n && trdy_n && term_code == 2'b11));
  assert_stop_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_n && !frame_n) |=> !stop_n);
  assert_release_together_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_n) |-> (devsel_n && trdy_n));
  assert_sticky_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    abort_fire |=> abort_flag);
endmodule

bind pci_tgt_term_ctl pci_tgt_term_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .devsel_n(devsel_n), .trdy_n(trdy_n),
  .stop_n(stop_n), .term_code(term_code), .abort_flag(abort_flag),
  .abort_fire(abort_fire), .cfg_txn(cfg_txn), .in_data(in_data)
);

// File: tb/pci_tgt_term_ctl_tb.sv
module pci_tgt_term_ctl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_n = 1, irdy_n = 1, sel_hit = 0, sel_cfg = 0, loc_rdy = 0;
  logic stop_rq = 0, abort_rq = 0, clr = 0;
  logic devsel_n, trdy_n, stop_n, abort_flag;
  logic [1:0] term_code;

  int checks = 0, errors = 0, cycles = 0;
  string cur_tag = "R1";

  always #2.5 clk = ~clk;

  pci_tgt_term_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .sel_hit(sel_hit),
    .sel_cfg(sel_cfg), .loc_rdy(loc_rdy), .loc_stop_req(stop_rq),
    .loc_abort_req(abort_rq), .abort_clr(clr), .devsel_n(devsel_n), .trdy_n(trdy_n),
    .stop_n(stop_n), .term_code(term_code), .abort_flag(abort_flag)
  );

  // Behavioural reference: asserted-high pin view, phase number, outcome.
  int m_phase = 0, m_code = 0;
  bit m_dev = 0, m_trdy = 0, m_stop = 0, m_seen = 0, m_cfg = 0, m_flag = 0;

  always @(posedge clk) begin
    bit fired;
    fired = 0;
    if (!rst_n) begin
      m_phase = 0; m_dev = 0; m_trdy = 0; m_stop = 0; m_code = 0; m_flag = 0; m_cfg = 0;
    end else begin
      if (m_phase == 0) begin
        if (!frame_n && sel_hit) begin
          m_phase = 1; m_dev = 1; m_trdy = 0; m_stop = 0; m_code = 0;
          m_cfg = sel_cfg; m_seen = 0;
        end
      end else if (m_phase == 1) begin
        if (frame_n && (irdy_n || m_trdy)) begin
          m_phase = 0; m_dev = 0; m_trdy = 0; m_stop = 0;
        end else begin
          if (!m_cfg && abort_rq) begin
            m_phase = 2; m_dev = 0; m_stop = 1; m_trdy = 0; m_code = 3; fired = 1;
          end else if (!m_cfg && stop_rq) begin
            m_phase = 2; m_stop = 1;
            if (!m_seen && !loc_rdy) begin m_code = 1; m_trdy = 0; end
            else begin m_code = 2; m_trdy = loc_rdy; end
          end else m_trdy = loc_rdy;
          if (loc_rdy) m_seen = 1;
        end
      end else begin
        if (frame_n && !irdy_n) begin
          m_phase = 0; m_dev = 0; m_trdy = 0; m_stop = 0;
        end else if (!irdy_n) m_trdy = 0;
      end
      if (fired) m_flag = 1;
      else if (clr) m_flag = 0;
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Clock-by-clock comparison against the model.
  always @(negedge clk) begin
    if (rst_n) begin
      chk(cur_tag, "devsel_n", devsel_n, !m_dev);
      chk(cur_tag, "trdy_n", trdy_n, !m_trdy);
      chk(cur_tag, "stop_n", stop_n, !m_stop);
      chk(cur_tag, "term_code", term_code, m_code);
      chk(cur_tag, "abort_flag", abort_flag, m_flag);
    end
  end

  task automatic cyc(bit fr, bit ir, bit hit, bit cf, bit rdy, bit st, bit ab, bit cl);
    frame_n = fr; irdy_n = ir; sel_hit = hit; sel_cfg = cf; loc_rdy = rdy;
    stop_rq = st; abort_rq = ab; clr = cl;
    @(negedge clk);
  endtask

  task automatic idle(); cyc(1, 1, 0, 0, 0, 0, 0, 0); endtask

  task automatic pins(string tag, int d, int t, int s, int c);
    chk(tag, "devsel_n", devsel_n, d);
    chk(tag, "trdy_n", trdy_n, t);
    chk(tag, "stop_n", stop_n, s);
    chk(tag, "term_code", term_code, c);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_tag = "R1";
    pins("R1", 1, 1, 1, 0);
    chk("R1", "abort_flag", abort_flag, 0);
    rst_n = 1;
    idle();
    pins("R1", 1, 1, 1, 0);

    // Retry: stop before any data.
    cur_tag = "R4";
    cyc(0, 1, 1, 0, 0, 0, 0, 0); pins("R2", 0, 1, 1, 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 0); pins("R4", 0, 1, 0, 1);
    cur_tag = "R9";
    cyc(0, 0, 0, 0, 0, 0, 0, 0); pins("R9", 0, 1, 0, 1);
    cyc(1, 0, 0, 0, 0, 0, 0, 0); pins("R9", 1, 1, 1, 1);
    idle();

    // Disconnect with data after earlier data.
    cur_tag = "R5";
    cyc(0, 1, 1, 0, 0, 0, 0, 0); pins("R2", 0, 1, 1, 0);
    cyc(0, 0, 0, 0, 1, 0, 0, 0); pins("R3", 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 1, 1, 0, 0); pins("R5", 0, 0, 0, 2);
    cyc(0, 0, 0, 0, 0, 0, 0, 0); pins("R9", 0, 1, 0, 2);
    cyc(1, 0, 0, 0, 0, 0, 0, 0); pins("R9", 1, 1, 1, 2);
    idle();

    // Stop together with the first ready: disconnect, not retry.
    cyc(0, 1, 1, 0, 0, 0, 0, 0);
    cyc(0, 1, 0, 0, 1, 1, 0, 0); pins("R5", 0, 0, 0, 2);
    cyc(0, 1, 0, 0, 0, 0, 0, 0); pins("R9", 0, 0, 0, 2);
    cyc(1, 0, 0, 0, 0, 0, 0, 0); pins("R9", 1, 1, 1, 2);
    idle();

    // Disconnect without data.
    cyc(0, 1, 1, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 0, 0, 0); pins("R3", 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 0); pins("R5", 0, 1, 0, 2);
    cyc(1, 0, 0, 0, 0, 0, 0, 0);
    idle();

    // Abort held from the claim clock; priority over stop.
    cur_tag = "R7";
    cyc(0, 1, 1, 0, 0, 1, 1, 0); pins("R6", 0, 1, 1, 0);
    cyc(0, 1, 0, 0, 0, 1, 1, 0); pins("R7", 1, 1, 0, 3);
    chk("R10", "abort_flag", abort_flag, 1);
    cyc(1, 0, 0, 0, 0, 0, 0, 0); pins("R9", 1, 1, 1, 3);
    cur_tag = "R10";
    cyc(1, 1, 0, 0, 0, 0, 0, 1); chk("R10", "abort_flag", abort_flag, 0);
    // Abort and clear together: set wins.
    cyc(0, 1, 1, 0, 0, 0, 0, 0);
    cyc(0, 1, 0, 0, 0, 0, 1, 1); chk("R10", "abort_flag", abort_flag, 1);
    pins("R6", 1, 1, 0, 3);
    cyc(1, 0, 0, 0, 0, 0, 0, 0);
    idle();

    // Configuration transaction ignores requests, then ends normally.
    cur_tag = "R8";
    cyc(0, 1, 1, 1, 0, 0, 0, 0); pins("R2", 0, 1, 1, 0);
    cyc(0, 0, 0, 0, 0, 1, 1, 0); pins("R8", 0, 1, 1, 0);
    chk("R8", "abort_flag", abort_flag, 1);
    cyc(0, 0, 0, 0, 0, 1, 0, 0); pins("R8", 0, 1, 1, 0);
    cur_tag = "R11";
    cyc(1, 0, 0, 0, 1, 1, 1, 0); pins("R8", 0, 0, 1, 0);
    cyc(1, 0, 0, 0, 0, 0, 0, 0); pins("R11", 1, 1, 1, 0);
    idle();

    // Plain memory transaction with a burst and normal completion.
    cyc(0, 1, 1, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 0, 0, 0); pins("R3", 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0); pins("R3", 0, 1, 1, 0);
    cyc(1, 0, 0, 0, 1, 0, 0, 0); pins("R3", 0, 0, 1, 0);
    cyc(1, 0, 0, 0, 0, 0, 0, 0); pins("R11", 1, 1, 1, 0);
    idle(); idle();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 5000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule